// File: doc/BRIEF.md
# UART Interrupt Status and Mask Controller

This block raises the single interrupt line of a UART. Every cycle it turns the receive and transmit FIFO occupancy counts and two programmable trigger levels into a word of live flags. It folds those flags, together with single-cycle error and timeout event pulses, into a sticky status register. The line is driven when any sticky bit is also enabled in an interrupt mask.

Software reaches the block through a small word-addressed register port. The mask is never written directly: one address ORs bits into it and another removes bits from it. Sticky status bits are cleared by writing ones to them. If a hardware source asserts a bit in the same cycle that software clears it, the bit stays set, so no event is lost. The FIFO storage, the serial shifting and the baud generation sit outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status word (read at address 4) holds: bit 0 when rx_count is at or above the receive trigger, bit 1 when rx_count is 0, bit 2 when rx_count equals FIFO_DEPTH (16), bit 3 when tx_count is 0, and bit 4 when tx_count equals FIFO_DEPTH. Every other live bit except bit 13 reads 0.
- R2: The transmit-trigger flag (tx_count at or above the transmit trigger) appears at bit 13 of the live word and at bit 10 of the sticky word.
- R3: On every clock edge, live bits 0 to 4 and the transmit-trigger flag are ORed into the sticky register (address 3). A live flag that drops again never clears a sticky bit.
- R4: A write to address 0 ORs the written data into the mask (read at address 2).
- R5: A write to address 1 clears the written one-bits from the mask. A write to address 2 leaves the mask unchanged.
- R6: A write to address 3 clears each sticky bit written as one and leaves each bit written as zero unchanged.
- R7: irq is high exactly when the mask ANDed with the sticky word is nonzero.
- R8: One-cycle event pulses set sticky bits on the next edge: receive overrun at bit 5, framing error at bit 6, parity error at bit 7, receive timeout at bit 8, modem status at bit 9, and transmit overrun at bit 12.
- R9: When a set source and a software clear hit the same sticky bit in the same cycle, the bit ends up set.
- R10: While rst_n is low (synchronous, active low), the mask and the sticky word are 0, irq is 0, and both trigger levels are 32.
- R11: The receive trigger (address 5) and the transmit trigger (address 6) take the low LVL_W bits of a write and read back that value. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | DATA_W (32) | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | DATA_W (32) | Combinational read data |
| rx_count | input | CNT_W (5) | Receive FIFO occupancy |
| tx_count | input | CNT_W (5) | Transmit FIFO occupancy |
| ev_rx_ovr | input | 1 | Receive overrun pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_ovr | input | 1 | Transmit overrun pulse |
| irq | output | 1 | Interrupt request |

## Verification
The live-status logic is driven with count and trigger pairs covering empty, full, exactly-at-trigger, one-below-trigger and zero-trigger cases. These separate off-by-one compare faults and swapped empty/full bits, and they show whether the transmit flag sits at bit 13 rather than bit 10. Each event input is pulsed alone, which exposes any miswired bit position. Combined pulses followed by a partial clear show whether write-one-clear touches only the written bits. A flag that is held for one cycle and then dropped tells a sticky register apart from a live one. Writing a clear while its source is still active shows that set wins over clear, and a run of mask set, clear and direct-write operations checks the interrupt gating.

// File: rtl/uart_irq_pkg.sv
// Package: shared bit positions, register addresses and event bundle for
// the UART interrupt controller. Positions here are behaviour: software
// decodes them, so they are fixed rather than parameters.
package uart_irq_pkg;

    localparam int STICKY_W    = 13;  // sticky status / active mask width
    localparam int LIVE_W      = 14;  // live status word width
    localparam int LIVE_SHARED = 5;   // live bits 0..4 copy straight into sticky

    localparam int B_RX_TRIG      = 0;
    localparam int B_RX_EMPTY     = 1;
    localparam int B_RX_FULL      = 2;
    localparam int B_TX_EMPTY     = 3;
    localparam int B_TX_FULL      = 4;
    localparam int B_RX_OVR       = 5;
    localparam int B_FRAME        = 6;
    localparam int B_PARITY       = 7;
    localparam int B_TIMEOUT      = 8;
    localparam int B_MODEM        = 9;
    localparam int B_TX_TRIG_STKY = 10;
    localparam int B_TX_OVR       = 12;
    localparam int B_TX_TRIG_LIVE = 13;

    typedef enum logic [2:0] {
        REG_MASK_SET = 3'd0,
        REG_MASK_CLR = 3'd1,
        REG_MASK     = 3'd2,
        REG_STICKY   = 3'd3,
        REG_LIVE     = 3'd4,
        REG_RX_TRIG  = 3'd5,
        REG_TX_TRIG  = 3'd6,
        REG_SPARE    = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic rx_ovr;
        logic frame;
        logic parity;
        logic timeout;
        logic modem;
        logic tx_ovr;
    } evt_t;

endpackage

// File: rtl/uart_irq_live.sv
// Module: live status builder. Purely combinational; turns the FIFO counts
// and the trigger levels into the live status word.
// Assumes counts never exceed FIFO_DEPTH.
module uart_irq_live
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = 6,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [LVL_W-1:0]  rx_trig,
    input  logic [LVL_W-1:0]  tx_trig,
    output logic [LIVE_W-1:0] live
);
    localparam int CMP_W = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    // Compare counts and triggers at a common width, then place each flag.
    always_comb begin
        live                 = '0;
        live[B_RX_TRIG]      = CMP_W'(rx_count) >= CMP_W'(rx_trig);
        live[B_RX_EMPTY]     = (rx_count == '0);
        live[B_RX_FULL]      = (rx_count == FULL_CNT);
        live[B_TX_EMPTY]     = (tx_count == '0);
        live[B_TX_FULL]      = (tx_count == FULL_CNT);
        live[B_TX_TRIG_LIVE] = CMP_W'(tx_count) >= CMP_W'(tx_trig);
    end
endmodule

// File: rtl/uart_irq_trig_regs.sv
// Module: holder for the two trigger-level registers. Each one loads the
// low LVL_W bits of a write to its address and resets to LVL_RESET.
module uart_irq_trig_regs
    import uart_irq_pkg::*;
#(
    parameter int LVL_W     = 6,
    parameter int LVL_RESET = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [LVL_W-1:0] wr_lvl,
    output logic [LVL_W-1:0] rx_trig,
    output logic [LVL_W-1:0] tx_trig
);
    // Load a trigger level on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_trig <= LVL_W'(LVL_RESET);
            tx_trig <= LVL_W'(LVL_RESET);
        end else if (wr_en) begin
            if (wr_addr == REG_RX_TRIG) rx_trig <= wr_lvl;
            if (wr_addr == REG_TX_TRIG) tx_trig <= wr_lvl;
        end
    end
endmodule

// File: rtl/uart_irq_sticky.sv
// Module: the mask and sticky status registers. The mask changes only
// through the set and clear addresses. Sticky bits are write-one-to-clear,
// and a set source outranks a clear arriving in the same cycle.
module uart_irq_sticky
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [LIVE_W-1:0]   live,
    input  evt_t                evt,
    output logic [DATA_W-1:0]   mask_q,
    output logic [STICKY_W-1:0] sticky_q
);
    logic [STICKY_W-1:0] set_vec;
    logic [STICKY_W-1:0] clr_vec;

    // Collect every hardware set source at its sticky position.
    always_comb begin
        set_vec = '0;
        for (int b = 0; b < LIVE_SHARED; b++) set_vec[b] = live[b];
        set_vec[B_TX_TRIG_STKY] = live[B_TX_TRIG_LIVE];
        set_vec[B_RX_OVR]       = evt.rx_ovr;
        set_vec[B_FRAME]        = evt.frame;
        set_vec[B_PARITY]       = evt.parity;
        set_vec[B_TIMEOUT]      = evt.timeout;
        set_vec[B_MODEM]        = evt.modem;
        set_vec[B_TX_OVR]       = evt.tx_ovr;
    end

    // Software clear vector, active only for a write to the sticky address.
    assign clr_vec = (wr_en && wr_addr == REG_STICKY) ? wr_data[STICKY_W-1:0] : '0;

    // Update the sticky bits: clear first, then OR the sources in, so set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~clr_vec) | set_vec;
    end

    // Update the mask through its set and clear addresses only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_MASK_SET)      mask_q <= mask_q | wr_data;
            else if (wr_addr == REG_MASK_CLR) mask_q <= mask_q & ~wr_data;
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: top of the UART interrupt controller. Wires the live builder,
// the trigger registers and the sticky/mask registers together, provides
// a combinational read mux, and drives irq from the registered mask and
// sticky state. Assumes at most one register write per cycle.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = 6,
    parameter int LVL_RESET  = 32,
    parameter int DATA_W     = 32,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              ev_rx_ovr,
    input  logic              ev_frame,
    input  logic              ev_parity,
    input  logic              ev_timeout,
    input  logic              ev_modem,
    input  logic              ev_tx_ovr,
    output logic              irq
);
    logic [LVL_W-1:0]    rx_trig;
    logic [LVL_W-1:0]    tx_trig;
    logic [LIVE_W-1:0]   live;
    logic [DATA_W-1:0]   mask_q;
    logic [STICKY_W-1:0] sticky_q;
    evt_t                evt;

    assign evt = '{rx_ovr: ev_rx_ovr, frame: ev_frame, parity: ev_parity,
                   timeout: ev_timeout, modem: ev_modem, tx_ovr: ev_tx_ovr};

    uart_irq_live #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) live_i (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_trig  (rx_trig),
        .tx_trig  (tx_trig),
        .live     (live)
    );

    uart_irq_trig_regs #(.LVL_W(LVL_W), .LVL_RESET(LVL_RESET)) trig_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_lvl  (wr_data[LVL_W-1:0]),
        .rx_trig (rx_trig),
        .tx_trig (tx_trig)
    );

    uart_irq_sticky #(.DATA_W(DATA_W)) sticky_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .live     (live),
        .evt      (evt),
        .mask_q   (mask_q),
        .sticky_q (sticky_q)
    );

    // Raise irq when an enabled sticky bit is set.
    assign irq = |(mask_q[STICKY_W-1:0] & sticky_q);

    // Select the register named by rd_addr.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_MASK:    rd_data = mask_q;
            REG_STICKY:  rd_data = DATA_W'(sticky_q);
            REG_LIVE:    rd_data = DATA_W'(live);
            REG_RX_TRIG: rd_data = DATA_W'(rx_trig);
            REG_TX_TRIG: rd_data = DATA_W'(tx_trig);
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Module: assertion checker for uart_irq_ctrl, attached with bind below.
// It observes the write port, event inputs, counts and the mask/sticky state.
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DATA_W     = 32,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [CNT_W-1:0]    rx_count,
    input logic                ev_rx_ovr,
    input logic [DATA_W-1:0]   mask_q,
    input logic [STICKY_W-1:0] sticky_q,
    input logic                irq
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_MASK_SET) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

    a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_MASK_CLR) |=> ((mask_q & $past(wr_data)) == '0));

    a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == REG_STICKY) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ovr |=> sticky_q[B_RX_OVR]);

    a_r1_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == FULL_CNT) |=> sticky_q[B_RX_FULL]);

    a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q[STICKY_W-1:0] != '0 && sticky_q != '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rx_count  (rx_count),
    .ev_rx_ovr (ev_rx_ovr),
    .mask_q    (mask_q),
    .sticky_q  (sticky_q),
    .irq       (irq)
);

// File: tb/uart_irq_ctrl_tb_top.sv
// Bench: a vector table for the live status word, then directed tests.
module uart_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [4:0]  rx_count = '0;
    logic [4:0]  tx_count = '0;
    logic [5:0]  ev_vec = '0;   // {tx_ovr, modem, timeout, parity, frame, rx_ovr}
    logic        irq;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_count(rx_count), .tx_count(tx_count),
        .ev_rx_ovr(ev_vec[0]), .ev_frame(ev_vec[1]), .ev_parity(ev_vec[2]),
        .ev_timeout(ev_vec[3]), .ev_modem(ev_vec[4]), .ev_tx_ovr(ev_vec[5]), .irq(irq)
    );

    typedef struct packed {
        logic [4:0]  rxc;
        logic [4:0]  txc;
        logic [5:0]  rtg;
        logic [5:0]  ttg;
        logic [13:0] live;
    } vec_t;

    // Expected live words follow R1 and R2 bit by bit.
    localparam vec_t VECS [7] = '{
        '{5'd0,  5'd0,  6'd32, 6'd32, 14'h000A},
        '{5'd16, 5'd16, 6'd32, 6'd32, 14'h0014},
        '{5'd5,  5'd3,  6'd5,  6'd4,  14'h0001},
        '{5'd4,  5'd4,  6'd5,  6'd4,  14'h2000},
        '{5'd16, 5'd0,  6'd16, 6'd0,  14'h200D},
        '{5'd0,  5'd16, 6'd1,  6'd16, 14'h2012},
        '{5'd15, 5'd15, 6'd16, 6'd16, 14'h0000}
    };
    localparam int EV_BIT [6] = '{5, 6, 7, 8, 9, 12};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_reg(string req, logic [2:0] a, logic [31:0] exp);
        logic [31:0] v;
        reg_read(a, v);
        check(req, v, exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check_reg("R10 mask", 3'd2, 32'h0);
        check_reg("R10 sticky", 3'd3, 32'h0);
        check_reg("R10 rx trig", 3'd5, 32'd32);
        check_reg("R10 tx trig", 3'd6, 32'd32);
        check("R10 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;

        // R1, R2, R11: table walk of the live status word
        foreach (VECS[i]) begin
            @(negedge clk);
            rx_count = VECS[i].rxc; tx_count = VECS[i].txc;
            reg_write(3'd5, {26'h3FFFFFF, VECS[i].rtg});
            reg_write(3'd6, {26'h0, VECS[i].ttg});
            check_reg("R11 rx trig readback", 3'd5, {26'b0, VECS[i].rtg});
            check_reg("R1 R2 live word", 3'd4, {18'b0, VECS[i].live});
        end
        check_reg("R11 spare address", 3'd7, 32'h0);

        // R6: clear all accumulated sticky bits with quiet live flags
        rx_count = 5'd8; tx_count = 5'd8;
        reg_write(3'd5, 32'd32);
        reg_write(3'd6, 32'd32);
        reg_write(3'd3, 32'h1FFF);
        check_reg("R6 clear all", 3'd3, 32'h0);

        // R8: each event pulse sets its own bit
        for (int e = 0; e < 6; e++) begin
            @(negedge clk); ev_vec = 6'(1 << e);
            @(negedge clk); ev_vec = '0;
            check_reg("R8 event bit", 3'd3, 32'(1 << EV_BIT[e]));
            reg_write(3'd3, 32'(1 << EV_BIT[e]));
        end

        // R6: partial clear keeps zero-written bits
        @(negedge clk); ev_vec = 6'b000110;
        @(negedge clk); ev_vec = '0;
        reg_write(3'd3, 32'h40);
        check_reg("R6 partial clear", 3'd3, 32'h80);
        reg_write(3'd3, 32'h80);

        // R3: a one-cycle live flag stays latched
        @(negedge clk); rx_count = 5'd0;
        @(negedge clk); rx_count = 5'd8;
        @(negedge clk);
        check_reg("R3 sticky after drop", 3'd3, 32'h2);
        check_reg("R3 live after drop", 3'd4, 32'h0);
        reg_write(3'd3, 32'h2);

        // R2: transmit trigger lands on sticky bit 10, live bit 13
        reg_write(3'd6, 32'd4);
        @(negedge clk);
        check_reg("R2 sticky bit10", 3'd3, 32'h400);
        check_reg("R2 live bit13", 3'd4, 32'h2000);

        // R4, R5, R7: mask manipulation and irq gating
        check("R7 irq masked off", {31'b0, irq}, 32'h0);
        reg_write(3'd0, 32'h400);
        check_reg("R4 mask set", 3'd2, 32'h400);
        check("R7 irq enabled", {31'b0, irq}, 32'h1);
        reg_write(3'd0, 32'h8000_0001);
        check_reg("R4 mask or", 3'd2, 32'h8000_0401);
        reg_write(3'd2, 32'h0);
        check_reg("R5 direct write ignored", 3'd2, 32'h8000_0401);
        reg_write(3'd1, 32'h400);
        check_reg("R5 mask clear", 3'd2, 32'h8000_0001);
        check("R7 irq after clear", {31'b0, irq}, 32'h0);

        // R9: set wins over a same-cycle clear
        reg_write(3'd3, 32'h400);
        check_reg("R9 live flag beats clear", 3'd3, 32'h400);
        @(negedge clk); ev_vec = 6'b001000;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h100;
        @(negedge clk);
        wr_en = 1'b0; ev_vec = '0;
        check_reg("R9 event beats clear", 3'd3, 32'h500);
        reg_write(3'd6, 32'd32);
        reg_write(3'd3, 32'h1FFF);
        check_reg("R6 final clear", 3'd3, 32'h0);

        // R10: reset in mid-run
        reg_write(3'd0, 32'h1);
        reg_write(3'd5, 32'd3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check_reg("R10 mask after reset", 3'd2, 32'h0);
        check_reg("R10 sticky after reset", 3'd3, 32'h0);
        check_reg("R10 rx trig after reset", 3'd5, 32'd32);
        check("R10 irq after reset", {31'b0, irq}, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule